// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

This block is a 4-bit counter with two independent count strobes: a rising edge on the up strobe adds one and a rising edge on the down strobe subtracts one. Both strobes are registered in the system clock domain and their 0-to-1 transitions are detected there. This lets the counter sit in an ordinary single-clock design while still behaving like a counter driven by two count clocks. A master clear and an active-low parallel load take effect on the count output at once. Counting resumes from the loaded value.

Two active-low terminal-count outputs support cascading. The carry output is low while the count is at its maximum and the up strobe is low. The borrow output is low while the count is zero and the down strobe is low. Each output returns high on the strobe's rising edge. A stage can therefore feed the up and down strobes of the next, more significant stage directly, and both stages step in the same system cycle.

A parameter selects binary (0 to 15) or decade (0 to 9) counting. In decade mode any code above 9 returns to the legal range after a single count.

Top module: `updn_counter4`

## Requirements
- R1: While `clr` is high, `count` is 0 in the same cycle, regardless of `load_n` and the strobes.
- R2: While `load_n` is low (and `clr` low), `count` equals `preset` without waiting for a clock edge; after `load_n` returns high the loaded value is held until a count event.
- R3: A rising edge of `up_stb` while `dn_stb` is high increments the count; in binary mode 15 is followed by 0.
- R4: A rising edge of `dn_stb` while `up_stb` is high decrements the count; in binary mode 0 is followed by 15.
- R5: Rising edges on both strobes in the same sampled cycle leave the count unchanged, and strobe edges that occur while `clr` is high or `load_n` is low are discarded.
- R6: `carry_n` is low exactly when `count` is at the maximum (9 in decade mode, 15 in binary mode) and `up_stb` is low.
- R7: `borrow_n` is low exactly when `count` is 0 and `dn_stb` is low.
- R8: In decade mode, counting up from 9 gives 0 and counting down from 0 gives 9.
- R9: In decade mode, an illegal code (10 to 15) counts up to 0 and counts down to 9.
- R10: Two decade stages cascade correctly when the first stage's `carry_n` drives the second stage's `up_stb` and its `borrow_n` drives the second stage's `dn_stb`: 39 counts up to 40, and 40 counts down to 39.
- R11: A rising edge of `up_stb` while `dn_stb` is low does not change the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock in which the strobes are sampled |
| clr | input | 1 | Master clear, active high, asynchronous |
| load_n | input | 1 | Parallel load enable, active low |
| preset | input | CNT_W | Value copied into the counter during load |
| up_stb | input | 1 | Up count strobe, counts on its rising edge |
| dn_stb | input | 1 | Down count strobe, counts on its rising edge |
| count | output | CNT_W | Current count |
| carry_n | output | 1 | Terminal count up, active low |
| borrow_n | output | 1 | Terminal count down, active low |

## Verification
The bound checker watches every cycle for several properties. The count must be zero under clear and must follow `preset` under load. Each detected up or down event must produce the stepped value of the previous count. With no event, the count must hold. The two terminal-count outputs must go low only in their stated conditions, and up and down events must never coincide. The bench scenarios cover behaviour that needs a chosen history: binary and decade wrap in both directions, the return from illegal decade codes, edges discarded during load or clear, simultaneous edges, and a two-stage cascade rolling over in both directions through the carry and borrow wiring.

// File: rtl/updn_pkg.sv
package updn_pkg;
  // Next value when counting up: the maximum and any code above it go to 0.
  function automatic int next_up(int cur, int max_cnt);
    return (cur >= max_cnt) ? 0 : cur + 1;
  endfunction

  // Next value when counting down: 0 and any code above the maximum go to the maximum.
  function automatic int next_dn(int cur, int max_cnt);
    return (cur == 0 || cur > max_cnt) ? max_cnt : cur - 1;
  endfunction
endpackage

// File: rtl/updn_stb_edge.sv
module updn_stb_edge (
  input  logic clk,
  input  logic clr,
  input  logic stb,
  output logic lvl,
  output logic rise
);
  logic s_q, s_qq;

  // Idle level is high, so clear presets both stages to 1.
  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      s_q  <= 1'b1;
      s_qq <= 1'b1;
    end else begin
      s_q  <= stb;
      s_qq <= s_q;
    end
  end

  assign lvl  = s_q;
  assign rise = s_q & ~s_qq;
endmodule

// File: rtl/updn_step.sv
module updn_step #(
  parameter int CNT_W   = 4,
  parameter int MAX_CNT = 15
) (
  input  logic [CNT_W-1:0] cur,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] nxt
);
  always_comb begin
    if (inc)
      nxt = CNT_W'(updn_pkg::next_up(int'(cur), MAX_CNT));
    else if (dec)
      nxt = CNT_W'(updn_pkg::next_dn(int'(cur), MAX_CNT));
    else
      nxt = cur;
  end
endmodule

// File: rtl/updn_tc.sv
module updn_tc #(
  parameter int CNT_W   = 4,
  parameter int MAX_CNT = 15
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             up_stb,
  input  logic             dn_stb,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(MAX_CNT);

  assign carry_n  = ~((cnt == TOP) & ~up_stb);
  assign borrow_n = ~((cnt == '0) & ~dn_stb);
endmodule

// File: rtl/updn_counter4.sv
module updn_counter4 #(
  parameter bit DECADE = 1'b0,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load_n,
  input  logic [CNT_W-1:0] preset,
  input  logic             up_stb,
  input  logic             dn_stb,
  output logic [CNT_W-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam int MAX_CNT = DECADE ? 9 : (1 << CNT_W) - 1;

  logic             up_lvl, up_rise, dn_lvl, dn_rise;
  logic             inc_evt, dec_evt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  updn_stb_edge u_up (.clk(clk), .clr(clr), .stb(up_stb), .lvl(up_lvl), .rise(up_rise));
  updn_stb_edge u_dn (.clk(clk), .clr(clr), .stb(dn_stb), .lvl(dn_lvl), .rise(dn_rise));

  // A step needs one strobe rising while the other rests high; load discards edges.
  assign inc_evt = up_rise & dn_lvl & ~dn_rise & load_n;
  assign dec_evt = dn_rise & up_lvl & ~up_rise & load_n;

  updn_step #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u_step (
    .cur(cnt_q), .inc(inc_evt), .dec(dec_evt), .nxt(cnt_nxt)
  );

  always_ff @(posedge clk or posedge clr) begin
    if (clr)          cnt_q <= '0;
    else if (!load_n) cnt_q <= preset;
    else              cnt_q <= cnt_nxt;
  end

  // Clear and load reach the output without waiting for an edge.
  assign count = clr ? '0 : (!load_n ? preset : cnt_q);

  updn_tc #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u_tc (
    .cnt(count), .up_stb(up_stb), .dn_stb(dn_stb),
    .carry_n(carry_n), .borrow_n(borrow_n)
  );
endmodule

// File: rtl/updn_counter4_chk.sv
module updn_counter4_chk #(
  parameter int CNT_W   = 4,
  parameter int MAX_CNT = 15
) (
  input logic             clk,
  input logic             clr,
  input logic             load_n,
  input logic [CNT_W-1:0] preset,
  input logic             up_stb,
  input logic             dn_stb,
  input logic [CNT_W-1:0] count,
  input logic             carry_n,
  input logic             borrow_n,
  input logic             inc_evt,
  input logic             dec_evt
);
  logic seen;
  always_ff @(posedge clk or posedge clr) begin
    if (clr) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  p_clr_zero_r1: assert property (@(posedge clk) clr |-> count == '0);

  p_load_follow_r2: assert property (@(posedge clk) disable iff (clr)
    !load_n |-> count == preset);

  p_step_up_r3: assert property (@(posedge clk) disable iff (clr)
    (seen && $past(inc_evt) && $past(load_n) && load_n)
      |-> count == CNT_W'(updn_pkg::next_up(int'($past(count)), MAX_CNT)));

  p_step_dn_r4: assert property (@(posedge clk) disable iff (clr)
    (seen && $past(dec_evt) && $past(load_n) && load_n)
      |-> count == CNT_W'(updn_pkg::next_dn(int'($past(count)), MAX_CNT)));

  p_hold_r5: assert property (@(posedge clk) disable iff (clr)
    (seen && !$past(inc_evt) && !$past(dec_evt) && $past(load_n) && load_n)
      |-> $stable(count));

  p_one_event_r5: assert property (@(posedge clk) disable iff (clr)
    $onehot0({inc_evt, dec_evt}));

  p_carry_r6: assert property (@(posedge clk) disable iff (clr)
    !carry_n |-> (count == CNT_W'(MAX_CNT) && !up_stb));

  p_borrow_r7: assert property (@(posedge clk) disable iff (clr)
    !borrow_n |-> (count == '0 && !dn_stb));
endmodule

bind updn_counter4 updn_counter4_chk #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u_chk (
  .clk(clk), .clr(clr), .load_n(load_n), .preset(preset),
  .up_stb(up_stb), .dn_stb(dn_stb), .count(count),
  .carry_n(carry_n), .borrow_n(borrow_n),
  .inc_evt(inc_evt), .dec_evt(dec_evt)
);

// File: tb/tb_updn_counter4.sv
`timescale 1ns/1ps
module tb_updn_counter4;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       clr = 1'b1;
  logic       lo_up = 1'b1, lo_dn = 1'b1, lo_ld_n = 1'b1;
  logic [3:0] lo_pre = '0, hi_pre = '0;
  logic       hi_ld_n = 1'b1;
  logic       bin_up = 1'b1, bin_dn = 1'b1, bin_ld_n = 1'b1;
  logic [3:0] bin_pre = '0;
  logic [3:0] lo_cnt, hi_cnt, bin_cnt;
  logic       lo_cy_n, lo_bw_n, hi_cy_n, hi_bw_n, bin_cy_n, bin_bw_n;

  int nvec = 0, nerr = 0;
  bit done = 1'b0;

  // Low decade stage (the main instance) cascaded into a high decade stage.
  updn_counter4 #(.DECADE(1'b1)) dut (
    .clk(clk), .clr(clr), .load_n(lo_ld_n), .preset(lo_pre),
    .up_stb(lo_up), .dn_stb(lo_dn), .count(lo_cnt),
    .carry_n(lo_cy_n), .borrow_n(lo_bw_n));
  updn_counter4 #(.DECADE(1'b1)) dut_hi (
    .clk(clk), .clr(clr), .load_n(hi_ld_n), .preset(hi_pre),
    .up_stb(lo_cy_n), .dn_stb(lo_bw_n), .count(hi_cnt),
    .carry_n(hi_cy_n), .borrow_n(hi_bw_n));
  updn_counter4 #(.DECADE(1'b0)) dut_bin (
    .clk(clk), .clr(clr), .load_n(bin_ld_n), .preset(bin_pre),
    .up_stb(bin_up), .dn_stb(bin_dn), .count(bin_cnt),
    .carry_n(bin_cy_n), .borrow_n(bin_bw_n));

  task automatic chk(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // which: 0 lo up, 1 lo dn, 2 bin up, 3 bin dn
  task automatic set_stb(int which, logic v);
    case (which)
      0: lo_up = v;
      1: lo_dn = v;
      2: bin_up = v;
      default: bin_dn = v;
    endcase
  endtask

  task automatic pulse(int which);
    set_stb(which, 1'b0); wait_n(3);
    set_stb(which, 1'b1); wait_n(3);
  endtask

  task automatic load_bin(logic [3:0] v);
    bin_pre = v; bin_ld_n = 1'b0; wait_n(2); bin_ld_n = 1'b1; wait_n(2);
  endtask

  task automatic load_lo(logic [3:0] v);
    lo_pre = v; lo_ld_n = 1'b0; wait_n(2); lo_ld_n = 1'b1; wait_n(2);
  endtask

  task automatic t_reset();
    clr = 1'b1; bin_pre = 4'd6; bin_ld_n = 1'b0; #1;
    chk("R1 clear overrides load", bin_cnt, 0);
    chk("R1 clear zeroes decade stage", lo_cnt, 0);
    set_stb(2, 1'b0); wait_n(2); set_stb(2, 1'b1); wait_n(2);
    bin_ld_n = 1'b1; clr = 1'b0; wait_n(3);
    chk("R5 edge during clear discarded", bin_cnt, 0);
  endtask

  task automatic t_load();
    @(negedge clk); bin_pre = 4'd7; bin_ld_n = 1'b0; #1;
    chk("R2 load visible at once", bin_cnt, 7);
    set_stb(2, 1'b0); wait_n(2); set_stb(2, 1'b1); wait_n(2);
    bin_ld_n = 1'b1; wait_n(3);
    chk("R2 loaded value held", bin_cnt, 7);
    chk("R5 edge during load discarded", bin_cnt, 7);
  endtask

  task automatic t_bin_up();
    load_bin(4'd14);
    pulse(2); chk("R3 increment 14", bin_cnt, 15);
    set_stb(2, 1'b0); #1;
    chk("R6 carry low at max with strobe low", bin_cy_n, 0);
    wait_n(3); set_stb(2, 1'b1); #1;
    chk("R6 carry high after strobe rises", bin_cy_n, 1);
    wait_n(3); chk("R3 binary wrap 15 to 0", bin_cnt, 0);
  endtask

  task automatic t_bin_dn();
    load_bin(4'd1);
    pulse(3); chk("R4 decrement 1", bin_cnt, 0);
    set_stb(3, 1'b0); #1;
    chk("R7 borrow low at zero with strobe low", bin_bw_n, 0);
    chk("R6 carry high away from max", bin_cy_n, 1);
    wait_n(3); set_stb(3, 1'b1); wait_n(3);
    chk("R4 binary wrap 0 to 15", bin_cnt, 15);
    chk("R7 borrow high at max", bin_bw_n, 1);
  endtask

  task automatic t_both();
    load_bin(4'd5);
    bin_up = 1'b0; bin_dn = 1'b0; wait_n(3);
    bin_up = 1'b1; bin_dn = 1'b1; wait_n(3);
    chk("R5 simultaneous edges no change", bin_cnt, 5);
  endtask

  task automatic t_up_dn_low();
    load_bin(4'd8);
    bin_dn = 1'b0; wait_n(3);
    pulse(2);
    chk("R11 up edge with down low ignored", bin_cnt, 8);
    bin_dn = 1'b1; wait_n(3);
    chk("R4 releasing down strobe decrements", bin_cnt, 7);
  endtask

  task automatic t_dec_wrap();
    hi_pre = 4'd0; hi_ld_n = 1'b0; load_lo(4'd8); hi_ld_n = 1'b1;
    pulse(0); chk("R8 decade 8 to 9", lo_cnt, 9);
    pulse(0); chk("R8 decade 9 to 0", lo_cnt, 0);
    pulse(1); chk("R8 decade 0 to 9", lo_cnt, 9);
  endtask

  task automatic t_dec_illegal();
    load_lo(4'd12);
    pulse(0); chk("R9 illegal 12 up to 0", lo_cnt, 0);
    load_lo(4'd14);
    pulse(1); chk("R9 illegal 14 down to 9", lo_cnt, 9);
    load_lo(4'd11);
    pulse(0); chk("R9 illegal 11 up to 0", lo_cnt, 0);
  endtask

  task automatic t_cascade();
    hi_pre = 4'd3; hi_ld_n = 1'b0; load_lo(4'd9); hi_ld_n = 1'b1; wait_n(1);
    chk("R10 cascade preset high", hi_cnt, 3);
    pulse(0);
    chk("R10 cascade up low digit", lo_cnt, 0);
    chk("R10 cascade up high digit", hi_cnt, 4);
    pulse(1);
    chk("R10 cascade down low digit", lo_cnt, 9);
    chk("R10 cascade down high digit", hi_cnt, 3);
  endtask

  initial begin
    wait_n(2);
    t_reset();
    t_load();
    t_bin_up();
    t_bin_dn();
    t_both();
    t_up_dn_low();
    t_dec_wrap();
    t_dec_illegal();
    t_cascade();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule